// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Timer

This block decides when the primary switch of a quasi-resonant flyback converter turns on and when it turns off again. Its time base is a free-running clock, and every duration is set as a parameter in nanoseconds. Each duration is converted to a cycle count from `CLK_HZ`, rounded to the nearest cycle, with a minimum of one cycle. The block takes three digitised comparator outputs:

- a sync comparator with hysteresis: high once the sync level has risen past the upper threshold, low once it has fallen past the lower threshold;
- a flag that says the sync level is above the high flat level;
- a flag that says the sensed switch current has passed the feedback level.

A new turn-on is blocked for a blanking interval measured from the previous turn-on. A bounded search window follows the blanking interval. In that window, the first valley starts a short delay and the switch then turns on. If the window runs out, the switch turns on anyway. The blanking interval and the window together set a minimum and a maximum switching period.

When the sync level is still flat-high at the moment blanking ends, the block does not wait for a valley. It turns on after a fixed delay instead. While the switch is on, the current-sense flag ends the pulse, but only after a leading-edge blanking interval. The pulse is also cut at a maximum on-time. A valley counter, cleared at every turn-on, is offered to an alternating-valley selector.

Top module: `qrv_timer`

## Requirements
- R1: While `rst` is high or `en` is low, `gate`, `on_pulse` and `valley_cnt` are 0 from the next clock edge. After release, timing restarts from the start of blanking. With no valley, the first turn-on comes PERIOD_C = BLANK_C + WIN_C cycles after release.
- R2: No turn-on occurs within BLANK_C cycles of the previous turn-on. A valley seen during blanking does not cause a turn-on.
- R3: A valley seen while the cycle counter is in [BLANK_C, PERIOD_C-1) turns the switch on VDLY_C+1 cycles after that valley's cycle, but never later than PERIOD_C cycles after the previous turn-on.
- R4: If no valley is found in the window, turn-on is forced exactly PERIOD_C cycles after the previous turn-on.
- R5: If `sync_flat_hi` is high in the last blanking cycle, turn-on comes FDLY_C cycles after blanking ends, that is BLANK_C+FDLY_C cycles after the previous turn-on. Valleys seen during that delay are ignored.
- R6: A valley is a 1-to-0 transition of `sync_cmp` between two consecutive samples. A `sync_cmp` that never falls produces no valley.
- R7: `gate` stays high for at most TON_C cycles per pulse.
- R8: `cs_trip` sampled high in on-time cycle j (counting from 0) ends the pulse after j+1 cycles when j >= LEB_C. When j < LEB_C it has no effect.
- R9: `on_pulse` is high for exactly one cycle, in the first cycle of each `gate` pulse.
- R10: `valley_cnt` counts valleys seen while the gate is off. It saturates at its all-ones value and reads 0 in the first cycle of each on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the gate off and restarts timing |
| sync_cmp | input | 1 | Hysteretic sync comparator output (1 above upper threshold) |
| sync_flat_hi | input | 1 | Sync level above the flat-high threshold |
| cs_trip | input | 1 | Current sense has reached the feedback level |
| gate | output | 1 | Switch on request |
| on_pulse | output | 1 | One-cycle marker of each turn-on |
| valley_cnt | output | VCNT_W | Valleys seen since the last turn-on, saturating |

## Verification
A wrong phase in the turn-on sequencer shows at the ports as a switching period that is off by a number of cycles. The error appears at the very next turn-on, because every turn-on is bounded by PERIOD_C cycles. A fault in the on-time logic changes the width of the following gate pulse. A broken valley detector or counter changes either the period or `valley_cnt` within one cycle of the sync edge. For these reasons the bench sweeps the valley position across blanking and the whole window, and sweeps the current-sense position across the on-time. It checks every period and every pulse width against the expected arithmetic.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

    typedef enum logic [1:0] {
        ST_ON     = 2'd0,
        ST_BLANK  = 2'd1,
        ST_SEARCH = 2'd2,
        ST_DELAY  = 2'd3
    } qrv_state_e;

    typedef struct packed {
        logic sync;
        logic flat;
        logic cs;
    } qrv_sense_t;

    function automatic int unsigned ns_to_cyc(input int unsigned hz, input int unsigned ns);
        longint unsigned c;
        c = ((longint'(hz) / 1000) * longint'(ns) + 64'd500000) / 64'd1000000;
        return (c == 0) ? 32'd1 : 32'(c);
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qrv_valley_det.sv
module qrv_valley_det #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             sync_in,
    input  logic             count_en,
    input  logic             cnt_clr,
    output logic             valley,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic sync_q;

    assign valley = sync_q & ~sync_in;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            sync_q <= 1'b0;
            cnt    <= '0;
        end else begin
            sync_q <= sync_in;
            if (cnt_clr) begin
                cnt <= '0;
            end else if (valley && count_en && cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/qrv_delay_timer.sv
module qrv_delay_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (!expired) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/qrv_ontime.sv
module qrv_ontime #(
    parameter int PC_W  = 8,
    parameter int LEB_C = 12,
    parameter int TON_C = 500
) (
    input  logic [PC_W-1:0] per_cnt,
    input  logic            cs_trip,
    output logic            end_on
);
    localparam logic [PC_W-1:0] LAST_V = PC_W'(TON_C - 1);
    localparam logic [PC_W-1:0] LEB_V  = PC_W'(LEB_C);

    logic at_max;
    assign at_max = (per_cnt >= LAST_V);

    generate
        if (LEB_C >= TON_C) begin : g_no_cs
            logic unused_cs;
            assign unused_cs = cs_trip;
            assign end_on    = at_max;
        end else begin : g_cs
            assign end_on = at_max || (cs_trip && per_cnt >= LEB_V);
        end
    endgenerate

endmodule

// File: rtl/qrv_timer.sv
module qrv_timer
    import qrv_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned BLANK_NS      = 15000,
    parameter int unsigned WINDOW_NS     = 6000,
    parameter int unsigned VALLEY_DLY_NS = 230,
    parameter int unsigned FLAT_DLY_NS   = 500,
    parameter int unsigned LEB_NS        = 250,
    parameter int unsigned TON_MAX_NS    = 10000,
    parameter int          VCNT_W        = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sync_cmp,
    input  logic              sync_flat_hi,
    input  logic              cs_trip,
    output logic              gate,
    output logic              on_pulse,
    output logic [VCNT_W-1:0] valley_cnt
);
    localparam int BLANK_C  = int'(ns_to_cyc(CLK_HZ, BLANK_NS));
    localparam int WIN_C    = int'(ns_to_cyc(CLK_HZ, WINDOW_NS));
    localparam int VDLY_C   = int'(ns_to_cyc(CLK_HZ, VALLEY_DLY_NS));
    localparam int FDLY_C   = int'(ns_to_cyc(CLK_HZ, FLAT_DLY_NS));
    localparam int LEB_C    = int'(ns_to_cyc(CLK_HZ, LEB_NS));
    localparam int TON_C    = int'(ns_to_cyc(CLK_HZ, TON_MAX_NS));
    localparam int PERIOD_C = BLANK_C + WIN_C;
    localparam int PC_W     = $clog2(PERIOD_C + 1);
    localparam int DW       = $clog2(int'(umax(VDLY_C, FDLY_C)) + 1);

    localparam logic [PC_W-1:0] BLANK_END = PC_W'(BLANK_C - 1);
    localparam logic [PC_W-1:0] LIMIT     = PC_W'(PERIOD_C - 1);
    localparam logic [PC_W-1:0] PC_MAX    = PC_W'(PERIOD_C);
    localparam logic [DW-1:0]   VDLY_V    = DW'(VDLY_C - 1);
    localparam logic [DW-1:0]   FDLY_V    = DW'(FDLY_C - 1);

    qrv_state_e      st, st_n;
    logic [PC_W-1:0] per_cnt;
    qrv_sense_t      sense;
    logic            hold;
    logic            turn_on;
    logic            end_on;
    logic            valley;
    logic            dly_load;
    logic [DW-1:0]   dly_val;
    logic            dly_done;
    logic            at_limit;

    assign sense    = '{sync: sync_cmp, flat: sync_flat_hi, cs: cs_trip};
    assign hold     = ~en;
    assign at_limit = (per_cnt == LIMIT);

    qrv_valley_det #(.CNT_W(VCNT_W)) u_valley (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .sync_in  (sense.sync),
        .count_en (st != ST_ON),
        .cnt_clr  (turn_on),
        .valley   (valley),
        .cnt      (valley_cnt)
    );

    qrv_delay_timer #(.W(DW)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (dly_val),
        .expired  (dly_done)
    );

    qrv_ontime #(.PC_W(PC_W), .LEB_C(LEB_C), .TON_C(TON_C)) u_ontime (
        .per_cnt (per_cnt),
        .cs_trip (sense.cs),
        .end_on  (end_on)
    );

    always_comb begin
        st_n     = st;
        turn_on  = 1'b0;
        dly_load = 1'b0;
        dly_val  = '0;
        unique case (st)
            ST_ON: begin
                if (end_on) st_n = ST_BLANK;
            end
            ST_BLANK: begin
                if (per_cnt >= BLANK_END) begin
                    if (sense.flat) begin
                        st_n     = ST_DELAY;
                        dly_load = 1'b1;
                        dly_val  = FDLY_V;
                    end else begin
                        st_n = ST_SEARCH;
                    end
                end
            end
            ST_SEARCH: begin
                if (at_limit) begin
                    turn_on = 1'b1;
                end else if (valley) begin
                    st_n     = ST_DELAY;
                    dly_load = 1'b1;
                    dly_val  = VDLY_V;
                end
            end
            ST_DELAY: begin
                if (at_limit || dly_done) turn_on = 1'b1;
            end
            default: st_n = ST_BLANK;
        endcase
        if (turn_on) st_n = ST_ON;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            st      <= ST_BLANK;
            per_cnt <= '0;
        end else begin
            st <= st_n;
            if (turn_on) begin
                per_cnt <= '0;
            end else if (per_cnt != PC_MAX) begin
                per_cnt <= per_cnt + 1'b1;
            end
        end
    end

    assign gate     = (st == ST_ON);
    assign on_pulse = gate && (per_cnt == '0);

endmodule

// File: rtl/qrv_timer_chk.sv
module qrv_timer_chk #(
    parameter int BLANK_C  = 750,
    parameter int PERIOD_C = 1050,
    parameter int TON_C    = 500,
    parameter int VCNT_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              gate,
    input logic              on_pulse,
    input logic [VCNT_W-1:0] valley_cnt
);
    localparam int SW = $clog2(PERIOD_C + 2);
    localparam logic [SW-1:0] S_MAX = SW'(PERIOD_C + 1);

    logic [SW-1:0] since;
    logic [SW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            since  <= '0;
            hi_run <= '0;
        end else begin
            if (on_pulse)           since <= SW'(1);
            else if (since != S_MAX) since <= since + 1'b1;
            if (!gate)               hi_run <= '0;
            else if (hi_run != S_MAX) hi_run <= hi_run + 1'b1;
        end
    end

    p_dis_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!gate && valley_cnt == '0));

    p_blank_r2: assert property (@(posedge clk) disable iff (rst)
        on_pulse |-> (since >= SW'(BLANK_C)));

    p_period_r4: assert property (@(posedge clk) disable iff (rst)
        en |-> (since <= SW'(PERIOD_C)));

    p_ton_max_r7: assert property (@(posedge clk) disable iff (rst)
        gate |-> (hi_run < SW'(TON_C)));

    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        on_pulse |-> (gate && !$past(gate)));

    p_cnt_clr_r10: assert property (@(posedge clk) disable iff (rst)
        on_pulse |-> (valley_cnt == '0));

endmodule

bind qrv_timer qrv_timer_chk #(
    .BLANK_C  (BLANK_C),
    .PERIOD_C (PERIOD_C),
    .TON_C    (TON_C),
    .VCNT_W   (VCNT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .gate       (gate),
    .on_pulse   (on_pulse),
    .valley_cnt (valley_cnt)
);

// File: tb/qrv_timer_tb_top.sv
module qrv_timer_tb_top;
    // With CLK_HZ = 4 MHz: blank 60, window 24, valley delay 3,
    // flat delay 5, leading-edge blank 4, max on-time 40 cycles.
    localparam int BL = 60, WN = 24, P = BL + WN, VD = 3, FD = 5, LB = 4, TN = 40;

    logic clk = 1'b0;
    logic rst = 1'b1, en = 1'b0;
    logic sync_cmp = 1'b0, sync_flat_hi = 1'b0, cs_trip = 1'b0;
    logic gate, on_pulse;
    logic [1:0] valley_cnt;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    qrv_timer #(
        .CLK_HZ(4_000_000), .BLANK_NS(15000), .WINDOW_NS(6000),
        .VALLEY_DLY_NS(750), .FLAT_DLY_NS(1250), .LEB_NS(1000),
        .TON_MAX_NS(10000), .VCNT_W(2)
    ) dut_i (
        .clk(clk), .rst(rst), .en(en), .sync_cmp(sync_cmp),
        .sync_flat_hi(sync_flat_hi), .cs_trip(cs_trip),
        .gate(gate), .on_pulse(on_pulse), .valley_cnt(valley_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_to_on(output int n);
        n = 0;
        while (!on_pulse && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Called at the falling edge that shows on_pulse (cycle k = 0).
    task automatic run_period(input int v, input int csk, input bit flat, input bit burst,
                              output int per, output int hi, output int vc);
        per = -1; hi = 0; vc = -1;
        for (int k = 0; k < 200; k++) begin
            if (k > 0 && on_pulse) begin
                per = k;
                break;
            end
            if (k == 1) chk("R9 single-cycle on_pulse", int'(on_pulse), 0);
            if (gate) hi++;
            if (v >= 0 && k == v + 1) vc = int'(valley_cnt);
            if (burst && k == 59) vc = int'(valley_cnt);
            cs_trip      = (k == csk);
            sync_cmp     = (v >= 0 && k == v - 1) || (burst && k >= 41 && k <= 57 && (k % 2) == 1);
            sync_flat_hi = flat && (k < BL);
            @(negedge clk);
        end
        cs_trip = 1'b0; sync_cmp = 1'b0; sync_flat_hi = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, per, hi, vc, exp;
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 gate in reset", int'(gate), 0);
        chk("R1 on_pulse in reset", int'(on_pulse), 0);
        chk("R1 valley_cnt in reset", int'(valley_cnt), 0);
        rst = 1'b0;
        count_to_on(n);
        chk("R1 first turn-on after reset", n, P);
        chk("R9 gate high with on_pulse", int'(gate), 1);

        // Current-sense sweep over the on-time (R7, R8, R4, R6 with sync low).
        for (int c = 0; c <= TN; c++) begin
            run_period(-1, c, 1'b0, 1'b0, per, hi, vc);
            exp = (c >= LB && c < TN) ? c + 1 : TN;
            chk((c >= LB && c < TN) ? "R8 cs ends pulse" : "R7 max on-time / R8 cs blanked", hi, exp);
            chk("R4 forced turn-on, R6 no valley", per, P);
        end

        // Valley sweep across late blanking and the whole window (R2, R3, R4, R10).
        for (int v = TN; v < P; v++) begin
            run_period(v, -1, 1'b0, 1'b0, per, hi, vc);
            exp = (v >= BL) ? ((v + VD + 1 < P) ? v + VD + 1 : P) : P;
            chk((v >= BL) ? "R3 valley turn-on" : "R2 valley in blanking ignored", per, exp);
            if (v + 1 < per) chk("R10 one valley counted", vc, 1);
        end

        // Valley while the gate is on is not counted (R10).
        run_period(10, -1, 1'b0, 1'b0, per, hi, vc);
        chk("R10 valley during on-time not counted", vc, 0);
        chk("R4 period after on-time valley", per, P);

        // Saturation of the valley counter (R10), nine valleys in blanking.
        run_period(-1, -1, 1'b0, 1'b1, per, hi, vc);
        chk("R10 counter saturates", vc, 3);
        chk("R2 blanking valleys ignored", per, P);

        // Flat-high sync at end of blanking (R5).
        run_period(-1, -1, 1'b1, 1'b0, per, hi, vc);
        chk("R5 flat-high delay", per, BL + FD);
        run_period(BL + 1, -1, 1'b1, 1'b0, per, hi, vc);
        chk("R5 valley during flat delay ignored", per, BL + FD);

        // Disable in mid pulse (R1).
        en = 1'b0;
        @(negedge clk);
        chk("R1 gate low after disable", int'(gate), 0);
        n = 0;
        for (int i = 0; i < 50; i++) begin
            sync_cmp = (i % 2 == 0);
            if (gate || on_pulse) n++;
            @(negedge clk);
        end
        sync_cmp = 1'b0;
        chk("R1 no gate while disabled", n, 0);
        chk("R1 valley_cnt cleared while disabled", int'(valley_cnt), 0);
        en = 1'b1;
        count_to_on(n);
        chk("R1 restart from blanking after enable", n, P);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule